// File: doc/BRIEF.md
# Register-Array LIFO Stack with Occupancy Flags

This block is a last-in, first-out store of eleven words held in a small register array. A stack pointer counts down as the stack fills, so the bottom entry sits at the highest location (10) and the newest entry at the lowest occupied location. Registered flags report whether the stack is full or empty. The pointer itself is also a port, so surrounding logic can see the fill level directly.

A push moves the pointer down one step and then stores the input word at the location it now indicates. A pop copies the word at the pointer into a held output register and then moves the pointer up one step. A request that cannot be honoured leaves the stack untouched and raises a one-cycle error pulse. Such a request is a push while the stack is full, or a pop while it is empty. Asserting both requests in the same cycle does nothing.

Top module: `lifo_regstack`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets the pointer `sp_o` to 11, `empty_o` to 1, `full_o` to 0, `err_o` to 0 and `dout_o` to 0.
- R2: A push (push_i=1, pop_i=0) while not full decrements `sp_o` by one and stores `din_i` at the new pointer value, all visible after the same clock edge.
- R3: After a legal push `empty_o` is 0, and `full_o` is 1 exactly when the new pointer value is 0.
- R4: A pop (pop_i=1, push_i=0) while not empty loads `dout_o` with the word at the current pointer and then increments `sp_o`, so words come back in the reverse order of their pushes.
- R5: After a legal pop `full_o` is 0, and `empty_o` is 1 exactly when the new pointer value is 11.
- R6: A push while full changes no pointer, flag or stored word, and `err_o` is 1 for the following cycle only.
- R7: A pop while empty changes no pointer, flag or output word, and `err_o` is 1 for the following cycle only.
- R8: push_i and pop_i high together is a no-op: pointer, flags, storage and `dout_o` keep their values and `err_o` stays 0.
- R9: `dout_o` holds its last popped value through every cycle that has no legal pop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request |
| din_i | input | DATA_W | Word to push |
| dout_o | output | DATA_W | Last popped word, registered |
| sp_o | output | PTR_W | Stack pointer (11 = empty, 0 = full) |
| full_o | output | 1 | Stack holds eleven words |
| empty_o | output | 1 | Stack holds no words |
| err_o | output | 1 | One-cycle pulse after a refused request |

## Verification
A corrupted pointer shows on `sp_o` in the cycle after the faulty edge. It also shows on `dout_o` at the next pop, because the wrong location is read. A flag that drifts from the pointer shows at once on `full_o` or `empty_o`, and at the next request on the boundary as a missing or spurious `err_o` pulse. A stored word that an ignored push overwrote stays hidden until the pop that reaches it, so the bench drains the full stack after each refused push and compares every word against its own model.

// File: rtl/lifo_pkg.sv
package lifo_pkg;
    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_PUSH = 2'b01,
        OP_POP  = 2'b10,
        OP_BOTH = 2'b11
    } stk_op_e;

    function automatic stk_op_e decode_op(input logic push, input logic pop);
        return stk_op_e'({pop, push});
    endfunction
endpackage

// File: rtl/lifo_store.sv
module lifo_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 11,
    parameter int PTR_W  = 4
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] cell_q [DEPTH];
    logic [DATA_W-1:0] cell_d [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cell
        always_comb begin
            cell_d[gi] = cell_q[gi];
            if (wr_en && (wr_idx == PTR_W'(gi))) begin
                cell_d[gi] = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            cell_q[gi] <= cell_d[gi];
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_idx == PTR_W'(i)) begin
                rd_data = cell_q[i];
            end
        end
    end
endmodule

// File: rtl/lifo_ctrl.sv
module lifo_ctrl
    import lifo_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 11,
    parameter int PTR_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_req,
    input  logic              pop_req,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [PTR_W-1:0]  wr_idx,
    output logic [PTR_W-1:0]  rd_idx,
    output logic [PTR_W-1:0]  sp,
    output logic              full,
    output logic              empty,
    output logic              err,
    output logic [DATA_W-1:0] dout
);
    localparam logic [PTR_W-1:0] SP_BOTTOM = PTR_W'(DEPTH);
    localparam logic [PTR_W-1:0] SP_TOP    = '0;

    typedef struct packed {
        logic [PTR_W-1:0]  sp;
        logic              full;
        logic              empty;
        logic              err;
        logic [DATA_W-1:0] dout;
    } ctl_state_t;

    ctl_state_t st_q, st_d;
    stk_op_e    op;
    logic       push_ok, pop_ok;
    logic [PTR_W-1:0] sp_dec_d, sp_inc_d;

    assign op       = decode_op(push_req, pop_req);
    assign push_ok  = (op == OP_PUSH) && !st_q.full;
    assign pop_ok   = (op == OP_POP)  && !st_q.empty;
    assign sp_dec_d = st_q.sp - PTR_W'(1);
    assign sp_inc_d = st_q.sp + PTR_W'(1);

    assign wr_en  = push_ok;
    assign wr_idx = sp_dec_d;
    assign rd_idx = st_q.sp;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        unique case (op)
            OP_PUSH: begin
                if (st_q.full) begin
                    st_d.err = 1'b1;
                end else begin
                    st_d.sp    = sp_dec_d;
                    st_d.full  = (sp_dec_d == SP_TOP);
                    st_d.empty = 1'b0;
                end
            end
            OP_POP: begin
                if (st_q.empty) begin
                    st_d.err = 1'b1;
                end else begin
                    st_d.dout  = rd_data;
                    st_d.sp    = sp_inc_d;
                    st_d.empty = (sp_inc_d == SP_BOTTOM);
                    st_d.full  = 1'b0;
                end
            end
            default: ;
        endcase
        if (rst) begin
            st_d.sp    = SP_BOTTOM;
            st_d.full  = 1'b0;
            st_d.empty = 1'b1;
            st_d.err   = 1'b0;
            st_d.dout  = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign sp    = st_q.sp;
    assign full  = st_q.full;
    assign empty = st_q.empty;
    assign err   = st_q.err;
    assign dout  = st_q.dout;

    AST_SP_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        st_q.sp <= SP_BOTTOM); // R1
    AST_PUSH_STEPS_DOWN: assert property (@(posedge clk) disable iff (rst)
        (push_req && !pop_req && !st_q.full) |=> (st_q.sp == $past(st_q.sp) - PTR_W'(1))); // R2
    AST_FULL_AT_TOP: assert property (@(posedge clk) disable iff (rst)
        st_q.full == (st_q.sp == SP_TOP)); // R3
    AST_POP_STEPS_UP: assert property (@(posedge clk) disable iff (rst)
        (pop_req && !push_req && !st_q.empty) |=> (st_q.sp == $past(st_q.sp) + PTR_W'(1))); // R4
    AST_EMPTY_AT_BOTTOM: assert property (@(posedge clk) disable iff (rst)
        st_q.empty == (st_q.sp == SP_BOTTOM)); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (push_req && !pop_req && st_q.full) |=> ($stable(st_q.sp) && st_q.err && st_q.full)); // R6
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (pop_req && !push_req && st_q.empty) |=> ($stable(st_q.sp) && $stable(st_q.dout) && st_q.err)); // R7
    AST_BOTH_IS_NOP: assert property (@(posedge clk) disable iff (rst)
        (push_req && pop_req) |=> ($stable(st_q.sp) && $stable(st_q.dout) && !st_q.err)); // R8
    AST_DOUT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !(pop_req && !push_req && !st_q.empty) |=> $stable(st_q.dout)); // R9
endmodule

// File: rtl/lifo_regstack.sv
module lifo_regstack #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 11,
    parameter int PTR_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [DATA_W-1:0] din_i,
    output logic [DATA_W-1:0] dout_o,
    output logic [PTR_W-1:0]  sp_o,
    output logic              full_o,
    output logic              empty_o,
    output logic              err_o
);
    logic              wr_en;
    logic [PTR_W-1:0]  wr_idx, rd_idx;
    logic [DATA_W-1:0] rd_data;

    lifo_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .push_req (push_i),
        .pop_req  (pop_i),
        .rd_data  (rd_data),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .rd_idx   (rd_idx),
        .sp       (sp_o),
        .full     (full_o),
        .empty    (empty_o),
        .err      (err_o),
        .dout     (dout_o)
    );

    lifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (din_i),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );
endmodule

// File: tb/lifo_regstack_tb.sv
`timescale 1ns/1ps
module lifo_regstack_tb;
    localparam int DW = 8;
    localparam int DP = 11;
    localparam int PW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic push_i = 1'b0, pop_i = 1'b0;
    logic [DW-1:0] din_i = '0;
    logic [DW-1:0] dout_o;
    logic [PW-1:0] sp_o;
    logic full_o, empty_o, err_o;

    always #5 clk = ~clk;

    lifo_regstack #(.DATA_W(DW), .DEPTH(DP), .PTR_W(PW)) u_dut (
        .clk(clk), .rst(rst), .push_i(push_i), .pop_i(pop_i), .din_i(din_i),
        .dout_o(dout_o), .sp_o(sp_o), .full_o(full_o), .empty_o(empty_o), .err_o(err_o)
    );

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [DW-1:0] mdl_mem [DP];
    int            mdl_sp = DP;
    bit            mdl_full = 1'b0, mdl_empty = 1'b1;
    logic [DW-1:0] mdl_dout = '0;
    logic [DW-1:0] exp_q [$];
    event          pop_done;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: compares each popped word against the scoreboard queue (R4)
    initial begin
        forever begin
            @(pop_done);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4 scoreboard underrun", 0, 1);
            end else begin
                logic [DW-1:0] e;
                e = exp_q.pop_front();
                chk(dout_o == e, "R4 popped word", int'(dout_o), int'(e));
            end
        end
    end

    // Driver: called at a falling edge, applies one request for one cycle
    task automatic do_op(input bit p, input bit q, input logic [DW-1:0] v);
        bit    ill, popv;
        string tag_sp, tag_fl;
        ill  = (p && !q && mdl_full) || (q && !p && mdl_empty);
        popv = 1'b0;
        if (p && q)          begin tag_sp = "R8"; tag_fl = "R8"; end
        else if (ill && p)   begin tag_sp = "R6"; tag_fl = "R6"; end
        else if (ill && q)   begin tag_sp = "R7"; tag_fl = "R7"; end
        else if (p)          begin tag_sp = "R2"; tag_fl = "R3"; end
        else                 begin tag_sp = "R4"; tag_fl = "R5"; end
        if (p && !q && !mdl_full) begin
            mdl_sp--;
            mdl_mem[mdl_sp] = v;
            mdl_full  = (mdl_sp == 0);
            mdl_empty = 1'b0;
        end
        if (q && !p && !mdl_empty) begin
            exp_q.push_back(mdl_mem[mdl_sp]);
            mdl_dout  = mdl_mem[mdl_sp];
            mdl_sp++;
            mdl_empty = (mdl_sp == DP);
            mdl_full  = 1'b0;
            popv = 1'b1;
        end
        push_i = p; pop_i = q; din_i = v;
        @(posedge clk);
        @(negedge clk);
        push_i = 1'b0; pop_i = 1'b0;
        chk(int'(sp_o) == mdl_sp, {tag_sp, " pointer"}, int'(sp_o), mdl_sp);
        chk(full_o == mdl_full, {tag_fl, " full flag"}, int'(full_o), int'(mdl_full));
        chk(empty_o == mdl_empty, {tag_fl, " empty flag"}, int'(empty_o), int'(mdl_empty));
        chk(err_o == ill, {tag_sp, " error pulse"}, int'(err_o), int'(ill));
        if (!popv) chk(dout_o == mdl_dout, "R9 output held", int'(dout_o), int'(mdl_dout));
        if (popv) ->pop_done;
        #1;
    endtask

    task automatic idle_check_err_gone();
        @(posedge clk);
        @(negedge clk);
        chk(err_o == 1'b0, "R6 R7 error lasts one cycle", int'(err_o), 0);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(int'(sp_o) == DP, "R1 reset pointer", int'(sp_o), DP);
        chk(empty_o == 1'b1, "R1 reset empty", int'(empty_o), 1);
        chk(full_o == 1'b0, "R1 reset full", int'(full_o), 0);
        chk(err_o == 1'b0, "R1 reset error", int'(err_o), 0);
        chk(dout_o == '0, "R1 reset output", int'(dout_o), 0);

        // pop on empty, both on empty
        do_op(1'b0, 1'b1, 8'h00);
        idle_check_err_gone();
        do_op(1'b1, 1'b1, 8'h5A);

        // fill completely
        for (int i = 0; i < DP; i++) do_op(1'b1, 1'b0, 8'(8'h10 + 8'(i * 7)));
        // refused push must not disturb any stored word
        do_op(1'b1, 1'b0, 8'hEE);
        idle_check_err_gone();
        do_op(1'b1, 1'b1, 8'hCC);
        // drain completely, LIFO order checked by the monitor
        for (int i = 0; i < DP; i++) do_op(1'b0, 1'b1, 8'h00);
        do_op(1'b0, 1'b1, 8'h00);
        idle_check_err_gone();

        // interleaved traffic
        do_op(1'b1, 1'b0, 8'hA1);
        do_op(1'b1, 1'b0, 8'hB2);
        do_op(1'b0, 1'b1, 8'h00);
        do_op(1'b1, 1'b1, 8'h77);
        do_op(1'b1, 1'b0, 8'hC3);
        do_op(1'b0, 1'b0, 8'h00);
        do_op(1'b0, 1'b1, 8'h00);
        do_op(1'b0, 1'b1, 8'h00);
        do_op(1'b0, 1'b1, 8'h00);

        // reset while holding data
        do_op(1'b1, 1'b0, 8'h3C);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        mdl_sp = DP; mdl_full = 1'b0; mdl_empty = 1'b1; mdl_dout = '0;
        chk(int'(sp_o) == DP, "R1 reset pointer after use", int'(sp_o), DP);
        chk(empty_o == 1'b1 && dout_o == '0, "R1 reset flags after use", int'(empty_o), 1);

        chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule